// File: doc/BRIEF.md
# Mailbox Packet Receive Sequencer

This block is the host side of a byte-wide mailbox link. After a start pulse it fetches one complete response packet from the device. The device has two byte registers behind a one-bit address: the data port at address 0 and the status register at address 1. A read strobe returns its byte on `dev_rdata` one clock later. Reading the data port consumes a byte. Reading the status register has no side effect.

The engine polls status until the frame flag appears, then reads the data port and checks for the normal-mode code. It then moves payload bytes, one per output-buffer-full indication, into a caller-owned buffer through a write port. The payload ends when the frame flag is seen in the same status sample as output-buffer-full, or when the buffer capacity is used up. After the payload, the engine reads the trailing byte and checks it against the end-of-command code. While the bytes go past, it extracts the big-endian length field from the packet header.

Each packet finishes with one `done` pulse. The pulse carries a result code and, on success, the packet length. Every status wait has its own cycle-count timeout.

Top module: `mbx_rx_seq`

## Requirements
- R1: After reset, `busy`, `done`, `dev_rd` and `buf_we` are low and `err_code` is 0.
- R2: A start with `cap` below 6 ends with `done` and code 1 (short buffer), and makes no device read and no buffer write.
- R3: The engine polls the status register (address 1) until bit 2, the frame flag, is set. It then makes one read of the data port (address 0). If that byte is not 0x01, the packet ends with code 3 (bad mode byte).
- R4: For each payload byte, the engine polls status until bit 0 (output-buffer-full) is set. If bit 2 is also set in that same sample, the payload is over. Otherwise it reads one data byte and writes it to the buffer at the next address, counting up from 0.
- R5: Once `cap` bytes have been written, no more payload bytes are read. The engine polls status for the frame flag and then goes on to the trailer.
- R6: After the payload, the engine reads one data byte. If that byte is not 0x03, the packet ends with code 5 (bad trailer).
- R7: The packet length is the 32-bit big-endian value in payload bytes 2 to 5, with byte 2 as the most significant. If it exceeds `cap`, the code is 6 (oversize). Otherwise the code is 0 and `pkt_len` shows the length.
- R8: Every status wait counts cycles from its own start. If its condition is still unmet after `TMO_CYCLES` cycles, the packet ends within a few more cycles. The code is 2 for a frame-flag wait and 4 for an output-buffer-full wait.
- R9: `busy` is high from an accepted start through the `done` cycle. `done` lasts one cycle. A start that arrives while busy is ignored. Device reads happen only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin receiving one packet |
| cap | input | CAP_W | Buffer capacity in bytes, sampled at start |
| dev_rd | output | 1 | Device read strobe |
| dev_addr | output | 1 | Device register select: 0 data, 1 status |
| dev_rdata | input | 8 | Read byte, valid the cycle after `dev_rd` |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | CAP_W | Buffer write address |
| buf_wdata | output | 8 | Buffer write byte |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle end-of-packet pulse |
| err_code | output | 3 | Result code, valid with `done` and held after it |
| pkt_len | output | 32 | Packet length, updated on success |

## Verification
A wrong state transition shows up at the ports at once. It produces a read at the wrong address or an extra data-port pop, and a device model that counts pops sees it on the same packet. A wrong byte index shows up as a misplaced buffer write or a wrong length, and this is visible at `done`. A timer that restarts wrongly moves the timeout code's arrival outside its cycle window. The bench also runs the cases where the capacity runs out exactly on the frame flag and where it runs out before the frame flag, since these exercise separate wait states.

// File: rtl/mbx_rx_pkg.sv
package mbx_rx_pkg;

    // status register bit positions
    localparam int ST_OUT_FULL  = 0;
    localparam int ST_IN_FULL   = 1;
    localparam int ST_FRAME     = 2;
    localparam int ST_AUX       = 3;
    localparam int ST_CMD_RDY   = 4;
    localparam int ST_DATA_RDY  = 5;

    localparam logic [7:0] CODE_NORMAL = 8'h01;
    localparam logic [7:0] CODE_END    = 8'h03;

    localparam int MIN_CAP   = 6;
    localparam int LEN_FIRST = 2;
    localparam int LEN_BYTES = 4;

    typedef enum logic {
        PORT_DATA = 1'b0,
        PORT_STAT = 1'b1
    } port_e;

    typedef enum logic [2:0] {
        RES_OK       = 3'd0,
        RES_SHORT    = 3'd1,
        RES_FRM_TMO  = 3'd2,
        RES_BAD_MODE = 3'd3,
        RES_DAT_TMO  = 3'd4,
        RES_BAD_TAIL = 3'd5,
        RES_OVERSIZE = 3'd6
    } res_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_FRM_REQ,
        SQ_FRM_CHK,
        SQ_MODE_REQ,
        SQ_MODE_CHK,
        SQ_OBF_REQ,
        SQ_OBF_CHK,
        SQ_BYTE_REQ,
        SQ_BYTE_CHK,
        SQ_END_REQ,
        SQ_END_CHK,
        SQ_TAIL_REQ,
        SQ_TAIL_CHK,
        SQ_FIN
    } seq_e;

    typedef struct packed {
        logic  rd;
        port_e sel;
    } bus_req_t;

    function automatic logic stat_bit(input logic [7:0] s, input int pos);
        return s[pos];
    endfunction

endpackage

// File: rtl/mbx_rx_timer.sv
module mbx_rx_timer #(
    parameter int TMO_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic expired
);
    localparam int CNT_W = $clog2(TMO_CYCLES + 2);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(TMO_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(TMO_CYCLES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en && cnt != CNT_TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt >= CNT_LIM);

endmodule

// File: rtl/mbx_rx_lencap.sv
module mbx_rx_lencap #(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       din,
    output logic [31:0]      len
);
    import mbx_rx_pkg::*;

    localparam logic [IDX_W-1:0] LO = IDX_W'(LEN_FIRST);
    localparam logic [IDX_W-1:0] HI = IDX_W'(LEN_FIRST + LEN_BYTES);

    logic in_field;
    assign in_field = (idx >= LO) && (idx < HI);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            len <= '0;
        end else if (we && in_field) begin
            len <= {len[23:0], din};
        end
    end

endmodule

// File: rtl/mbx_rx_seq.sv
module mbx_rx_seq #(
    parameter int CAP_W      = 16,
    parameter int TMO_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CAP_W-1:0] cap,
    output logic             dev_rd,
    output logic             dev_addr,
    input  logic [7:0]       dev_rdata,
    output logic             buf_we,
    output logic [CAP_W-1:0] buf_addr,
    output logic [7:0]       buf_wdata,
    output logic             busy,
    output logic             done,
    output logic [2:0]       err_code,
    output logic [31:0]      pkt_len
);
    import mbx_rx_pkg::*;

    localparam logic [CAP_W-1:0] CAP_MIN = CAP_W'(MIN_CAP);

    seq_e             st, st_nx;
    res_e             res_q, res_nx;
    logic [CAP_W-1:0] cap_q;
    logic [CAP_W-1:0] idx_q;
    logic [31:0]      len_run;
    logic [31:0]      len_q;
    bus_req_t         req;
    logic             tmo_clr, tmo_en, tmo_exp;
    logic             take_byte, frm_seen, obf_seen;

    assign frm_seen = stat_bit(dev_rdata, ST_FRAME);
    assign obf_seen = stat_bit(dev_rdata, ST_OUT_FULL);

    mbx_rx_timer #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmo_clr),
        .en      (tmo_en),
        .expired (tmo_exp)
    );

    mbx_rx_lencap #(.IDX_W(CAP_W)) u_len (
        .clk (clk),
        .rst (rst),
        .clr (st == SQ_IDLE),
        .we  (take_byte),
        .idx (idx_q),
        .din (dev_rdata),
        .len (len_run)
    );

    always_comb begin
        st_nx     = st;
        res_nx    = res_q;
        req       = '{rd: 1'b0, sel: PORT_STAT};
        tmo_clr   = 1'b0;
        tmo_en    = 1'b0;
        take_byte = 1'b0;
        unique case (st)
            SQ_IDLE: begin
                tmo_clr = 1'b1;
                if (start) begin
                    if (cap < CAP_MIN) begin
                        res_nx = RES_SHORT;
                        st_nx  = SQ_FIN;
                    end else begin
                        st_nx  = SQ_FRM_REQ;
                    end
                end
            end
            SQ_FRM_REQ, SQ_OBF_REQ, SQ_END_REQ: begin
                tmo_en = 1'b1;
                req    = '{rd: 1'b1, sel: PORT_STAT};
                st_nx  = (st == SQ_FRM_REQ) ? SQ_FRM_CHK :
                         (st == SQ_OBF_REQ) ? SQ_OBF_CHK : SQ_END_CHK;
            end
            SQ_FRM_CHK, SQ_END_CHK: begin
                tmo_en = 1'b1;
                if (frm_seen) begin
                    st_nx = (st == SQ_FRM_CHK) ? SQ_MODE_REQ : SQ_TAIL_REQ;
                end else if (tmo_exp) begin
                    res_nx = RES_FRM_TMO;
                    st_nx  = SQ_FIN;
                end else begin
                    st_nx = (st == SQ_FRM_CHK) ? SQ_FRM_REQ : SQ_END_REQ;
                end
            end
            SQ_MODE_REQ, SQ_BYTE_REQ, SQ_TAIL_REQ: begin
                req   = '{rd: 1'b1, sel: PORT_DATA};
                st_nx = (st == SQ_MODE_REQ) ? SQ_MODE_CHK :
                        (st == SQ_BYTE_REQ) ? SQ_BYTE_CHK : SQ_TAIL_CHK;
            end
            SQ_MODE_CHK: begin
                tmo_clr = 1'b1;
                if (dev_rdata == CODE_NORMAL) begin
                    st_nx = SQ_OBF_REQ;
                end else begin
                    res_nx = RES_BAD_MODE;
                    st_nx  = SQ_FIN;
                end
            end
            SQ_OBF_CHK: begin
                tmo_en = 1'b1;
                if (obf_seen) begin
                    st_nx = frm_seen ? SQ_TAIL_REQ : SQ_BYTE_REQ;
                end else if (tmo_exp) begin
                    res_nx = RES_DAT_TMO;
                    st_nx  = SQ_FIN;
                end else begin
                    st_nx = SQ_OBF_REQ;
                end
            end
            SQ_BYTE_CHK: begin
                take_byte = 1'b1;
                tmo_clr   = 1'b1;
                st_nx     = (idx_q + 1'b1 == cap_q) ? SQ_END_REQ : SQ_OBF_REQ;
            end
            SQ_TAIL_CHK: begin
                st_nx = SQ_FIN;
                if (dev_rdata != CODE_END) begin
                    res_nx = RES_BAD_TAIL;
                end else if (len_run > 32'(cap_q)) begin
                    res_nx = RES_OVERSIZE;
                end else begin
                    res_nx = RES_OK;
                end
            end
            SQ_FIN: begin
                st_nx = SQ_IDLE;
            end
            default: st_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SQ_IDLE;
            res_q <= RES_OK;
            cap_q <= '0;
            idx_q <= '0;
            len_q <= '0;
        end else begin
            st    <= st_nx;
            res_q <= res_nx;
            if (st == SQ_IDLE && start) begin
                cap_q <= cap;
                idx_q <= '0;
            end
            if (take_byte) begin
                idx_q <= idx_q + 1'b1;
            end
            if (st == SQ_TAIL_CHK && res_nx == RES_OK) begin
                len_q <= len_run;
            end
        end
    end

    assign dev_rd    = req.rd;
    assign dev_addr  = req.sel;
    assign buf_we    = take_byte;
    assign buf_addr  = idx_q;
    assign buf_wdata = dev_rdata;
    assign busy      = (st != SQ_IDLE);
    assign done      = (st == SQ_FIN);
    assign err_code  = res_q;
    assign pkt_len   = len_q;

    // reads and writes only while a packet is in progress
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!dev_rd && !buf_we));

    assert_single_done_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // every buffer write follows a data-port read
    assert_we_after_data_R4: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> $past(dev_rd && dev_addr == PORT_DATA));

    assert_we_in_cap_R5: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> (buf_addr < cap_q));

    assert_ok_fits_R7: assert property (@(posedge clk) disable iff (rst)
        (done && err_code == RES_OK) |-> (pkt_len <= 32'(cap_q)));

    assert_tmo_cause_R8: assert property (@(posedge clk) disable iff (rst)
        (done && (err_code == RES_FRM_TMO || err_code == RES_DAT_TMO)) |-> $past(tmo_exp));

endmodule

// File: tb/sim_mbx_rx_seq.sv
module sim_mbx_rx_seq;
    localparam int CAP_W = 16;
    localparam int TMO   = 40;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [CAP_W-1:0] cap = '0;
    logic             dev_rd, dev_addr;
    logic [7:0]       dev_rdata = 8'h00;
    logic             buf_we;
    logic [CAP_W-1:0] buf_addr;
    logic [7:0]       buf_wdata;
    logic             busy, done;
    logic [2:0]       err_code;
    logic [31:0]      pkt_len;

    always #10 clk = ~clk;

    mbx_rx_seq #(.CAP_W(CAP_W), .TMO_CYCLES(TMO)) u0 (
        .clk(clk), .rst(rst), .start(start), .cap(cap),
        .dev_rd(dev_rd), .dev_addr(dev_addr), .dev_rdata(dev_rdata),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .busy(busy), .done(done), .err_code(err_code), .pkt_len(pkt_len)
    );

    // device model: a byte queue, each byte tagged with the frame flag
    logic [7:0] q_byte [0:31];
    logic       q_frm  [0:31];
    int         q_n    = 0;
    int         gap_set = 0;
    logic       ld = 1'b0;
    int         head = 0;
    int         gap = 0;
    int         n_dread = 0;
    int         n_read = 0;
    int         n_wr = 0;
    logic [7:0] mem [0:63];
    logic       avail;

    assign avail = (head < q_n) && (gap == 0);

    always @(posedge clk) begin
        if (ld) begin
            head <= 0;
            gap  <= 0;
        end else begin
            if (gap > 0) gap <= gap - 1;
            if (dev_rd) begin
                n_read <= n_read + 1;
                if (dev_addr) begin
                    dev_rdata <= {5'b0, avail && q_frm[head], 1'b0, avail};
                end else begin
                    n_dread   <= n_dread + 1;
                    dev_rdata <= (head < q_n) ? q_byte[head] : 8'hFF;
                    head      <= head + 1;
                    gap       <= gap_set;
                end
            end
        end
        if (buf_we) begin
            mem[buf_addr[5:0]] <= buf_wdata;
            n_wr <= n_wr + 1;
        end
    end

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pay(input int i, input int len);
        if (i == 0) return 8'hC1;
        if (i == 1) return 8'h00;
        if (i >= 2 && i <= 5) return 8'((len >> (8 * (5 - i))) & 255);
        return 8'(i * 7 + 3);
    endfunction

    // load: mode byte, npay payload bytes, trailer (if with_tail)
    task automatic load(input logic [7:0] mode, input int npay, input int len,
                        input logic [7:0] tail, input bit with_tail, input int g);
        q_byte[0] = mode; q_frm[0] = 1'b1;
        for (int i = 0; i < npay; i++) begin
            q_byte[i+1] = pay(i, len);
            q_frm[i+1]  = 1'b0;
        end
        q_byte[npay+1] = tail; q_frm[npay+1] = 1'b1;
        q_n     = with_tail ? npay + 2 : npay + 1;
        gap_set = g;
        ld = 1'b1;
        @(negedge clk);
        ld = 1'b0;
    endtask

    int dr0, rd0, wr0, cyc;

    task automatic run(input int c, input bit extra_start);
        dr0 = n_dread; rd0 = n_read; wr0 = n_wr; cyc = 0;
        cap = CAP_W'(c);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (extra_start && cyc == 9) start = 1'b1;
            if (extra_start && cyc == 10) start = 1'b0;
        end
    endtask

    task automatic t_reset;
        chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
        chk(!dev_rd && !buf_we, "R1", "strobes after reset", {dev_rd, buf_we}, 0);
        chk(err_code == 0, "R1", "code after reset", err_code, 0);
    endtask

    task automatic t_short;
        load(8'h01, 6, 6, 8'h03, 1, 0);
        run(5, 0);
        chk(done && err_code == 1, "R2", "short code", err_code, 1);
        chk(n_read == rd0 && n_wr == wr0, "R2", "accesses on short", n_read - rd0 + n_wr - wr0, 0);
        @(negedge clk);
        chk(!busy && !done, "R9", "done single cycle", {busy, done}, 0);
    endtask

    task automatic t_normal;
        load(8'h01, 10, 10, 8'h03, 1, 0);
        run(16, 0);
        chk(err_code == 0, "R7", "normal code", err_code, 0);
        chk(pkt_len == 10, "R7", "normal length", pkt_len, 10);
        chk(n_wr - wr0 == 10, "R4", "normal writes", n_wr - wr0, 10);
        chk(n_dread - dr0 == 12, "R6", "normal data reads", n_dread - dr0, 12);
        for (int i = 0; i < 10; i++)
            chk(mem[i] == pay(i, 10), "R4", "buffer byte", mem[i], pay(i, 10));
    endtask

    task automatic t_exact_cap;
        load(8'h01, 6, 6, 8'h03, 1, 3);
        run(6, 1);
        chk(err_code == 0 && pkt_len == 6, "R5", "exact cap length", pkt_len, 6);
        chk(n_wr - wr0 == 6, "R5", "exact cap writes", n_wr - wr0, 6);
        chk(n_dread - dr0 == 8, "R9", "restart ignored, reads", n_dread - dr0, 8);
    endtask

    task automatic t_bigend;
        load(8'h01, 8, 32'h0000_0107, 8'h03, 1, 1);
        run(300, 0);
        chk(err_code == 0 && pkt_len == 32'h107, "R7", "big-endian length", pkt_len, 32'h107);
    endtask

    task automatic t_oversize;
        load(8'h01, 8, 20, 8'h03, 1, 0);
        run(12, 0);
        chk(err_code == 6, "R7", "oversize code", err_code, 6);
        chk(pkt_len == 32'h107, "R7", "length held on error", pkt_len, 32'h107);
    endtask

    task automatic t_overrun;
        load(8'h01, 8, 8, 8'h03, 1, 0);
        run(6, 0);
        chk(err_code == 2, "R5", "overrun waits frame, code", err_code, 2);
        chk(n_wr - wr0 == 6, "R5", "overrun writes", n_wr - wr0, 6);
        chk(n_dread - dr0 == 7, "R5", "overrun data reads", n_dread - dr0, 7);
    endtask

    task automatic t_bad_mode;
        load(8'h02, 6, 6, 8'h03, 1, 0);
        run(16, 0);
        chk(err_code == 3, "R3", "bad mode code", err_code, 3);
        chk(n_dread - dr0 == 1 && n_wr == wr0, "R3", "bad mode reads", n_dread - dr0, 1);
    endtask

    task automatic t_bad_tail;
        load(8'h01, 7, 7, 8'h04, 1, 0);
        run(16, 0);
        chk(err_code == 5, "R6", "bad trailer code", err_code, 5);
    endtask

    task automatic t_frm_tmo;
        q_n = 0;
        ld = 1'b1; @(negedge clk); ld = 1'b0;
        run(16, 0);
        chk(err_code == 2, "R8", "frame timeout code", err_code, 2);
        chk(cyc >= TMO && cyc <= TMO + 8, "R8", "frame timeout cycles", cyc, TMO);
        chk(n_dread == dr0, "R3", "no data read before frame", n_dread - dr0, 0);
    endtask

    task automatic t_dat_tmo;
        load(8'h01, 0, 0, 8'h03, 0, 0);
        run(16, 0);
        chk(err_code == 4, "R8", "data timeout code", err_code, 4);
        chk(n_wr == wr0, "R8", "data timeout writes", n_wr - wr0, 0);
    endtask

    task automatic t_gap_restart;
        // gap longer than half the timeout per byte, total well beyond it
        load(8'h01, 8, 8, 8'h03, 1, TMO - 8);
        run(16, 0);
        chk(err_code == 0 && pkt_len == 8, "R8", "timer restarts per wait", err_code, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_short();
        t_normal();
        t_exact_cap();
        t_bigend();
        t_oversize();
        t_overrun();
        t_bad_mode();
        t_bad_tail();
        t_frm_tmo();
        t_dat_tmo();
        t_gap_restart();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule